// File: doc/BRIEF.md
# Source-Routed Hop Header Processor

This block performs the per-hop forwarding decision of a router in a two-dimensional mesh where every packet carries its complete path. The path is built at the sending node and stored in the head flit as an ordered string of 3-bit direction codes. When a head flit arrives, the block takes the leftmost code and steers the flit to one of five outputs: east, west, north, south or the local node. Before the flit leaves, the block shifts that code out of the route field. The next router therefore finds its own code in the leftmost slot.

Body and tail flits carry no route. They follow the output that the head of their packet opened, and that output stays held until the closing flit is accepted downstream. The input and each of the five outputs use a valid/ready handshake. The data path is combinational. A flit presented on the input appears on its selected output in the same cycle, and the input is accepted only when that output is ready.

Flit layout, from most significant bit down:
- Type: 2 bits. 0 is head, 1 is body, 2 is tail and 3 is single.
- Route field: MAX_HOPS slots of CODE_W bits each. Slot 0 is the most significant slot.
- Payload: PAYLOAD_W bits.

Output ports are indexed 0 east, 1 west, 2 north, 3 south and 4 local.

Top module: `hop_src_router`

## Requirements
- R1: After reset no packet is held. With in_valid low every out_valid bit is 0. A body or tail flit that arrives with no packet held is steered to the local port (index 4).
- R2: A head or single flit whose leftmost code is 1 goes to port 0 (east). Code 2 goes to port 1 (west), code 3 to port 2 (north) and code 4 to port 3 (south).
- R3: A head or single flit whose leftmost code is 0 (eject), or any unassigned code from 5 to 7, goes to the local port 4.
- R4: A forwarded head or single flit has its route field shifted left by one 3-bit slot, with zeros filling the rightmost slot. Its type and payload are unchanged.
- R5: Once a head flit is accepted, the body and tail flits that follow leave on the same port as that head, with every bit unchanged.
- R6: The held port is released when a tail or single flit is accepted. After that, a body or tail flit without a new head goes to the local port.
- R7: in_ready equals out_ready of the selected port, and the ready inputs of the other ports have no effect. A flit that is not accepted leaves the held state unchanged, and its output stays the same while the input is held.
- R8: At most one out_valid bit is high, and only while in_valid is high.
- R9: Feeding each output back as the next hop's input, the route east, east, north, north, north, eject carries a packet from (0,0) to (2,3), where it leaves on the local port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Input flit accepted when high with in_valid |
| in_flit | input | FLIT_W (58) | Input flit {type, route, payload} |
| out_valid | output | 5 | Per-port output valid (0 E, 1 W, 2 N, 3 S, 4 local) |
| out_ready | input | 5 | Per-port downstream ready |
| out_flit | output | 5*FLIT_W (290) | Per-port output flit; port p occupies bits [p*FLIT_W +: FLIT_W] |

## Verification
Single flits that carry each of the eight code values separate the four link directions from the local port, and also separate the real eject code from the unassigned codes. Multi-flit packets are sent while the other ports' ready lines toggle. These show that body and tail flits follow the held port rather than any bits of their own, and that a release happens only on tail or single acceptance. A stalled head with its output blocked shows that nothing latches before acceptance. A six-hop chain fed back through the block checks the coordinate arithmetic end to end. A long pseudo-random stream of types, codes and ready patterns is compared against a behavioural model on every cycle and exercises orphan body flits and back-to-back heads.

// File: rtl/hop_pkg.sv
package hop_pkg;
   localparam int NPORT      = 5;
   localparam int PIDX_W     = 3;
   localparam int TYPE_W     = 2;

   localparam int DIR_EJECT  = 0;
   localparam int DIR_EAST   = 1;
   localparam int DIR_WEST   = 2;
   localparam int DIR_NORTH  = 3;
   localparam int DIR_SOUTH  = 4;

   typedef enum logic [PIDX_W-1:0] {
      P_EAST  = 3'd0,
      P_WEST  = 3'd1,
      P_NORTH = 3'd2,
      P_SOUTH = 3'd3,
      P_LOCAL = 3'd4
   } port_e;

   typedef enum logic [TYPE_W-1:0] {
      FT_HEAD   = 2'd0,
      FT_BODY   = 2'd1,
      FT_TAIL   = 2'd2,
      FT_SINGLE = 2'd3
   } ftype_e;
endpackage

// File: rtl/hop_dir_decode.sv
module hop_dir_decode
   import hop_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic [CODE_W-1:0] code,
   output port_e             port
);
   always_comb begin
      if (code == CODE_W'(DIR_EAST))       port = P_EAST;
      else if (code == CODE_W'(DIR_WEST))  port = P_WEST;
      else if (code == CODE_W'(DIR_NORTH)) port = P_NORTH;
      else if (code == CODE_W'(DIR_SOUTH)) port = P_SOUTH;
      else                                 port = P_LOCAL;
   end
endmodule

// File: rtl/hop_route_strip.sv
module hop_route_strip #(
   parameter int CODE_W   = 3,
   parameter int MAX_HOPS = 8,
   localparam int ROUTE_W = CODE_W * MAX_HOPS
) (
   input  logic [ROUTE_W-1:0] route_in,
   output logic [ROUTE_W-1:0] route_out
);
   genvar s;
   generate
      for (s = 0; s < MAX_HOPS; s++) begin : g_slot
         localparam int HI = ROUTE_W - 1 - s * CODE_W;
         if (s == MAX_HOPS - 1) begin : g_fill
            assign route_out[HI -: CODE_W] = '0;
         end else begin : g_move
            assign route_out[HI -: CODE_W] = route_in[HI - CODE_W -: CODE_W];
         end
      end
   endgenerate
endmodule

// File: rtl/hop_port_lock.sv
module hop_port_lock
   import hop_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   accept,
   input  ftype_e ftype,
   input  port_e  head_port,
   output logic   locked,
   output port_e  held_port
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked    <= 1'b0;
         held_port <= P_LOCAL;
      end else if (accept) begin
         if (ftype == FT_HEAD) begin
            locked    <= 1'b1;
            held_port <= head_port;
         end else if (ftype == FT_TAIL || ftype == FT_SINGLE) begin
            locked    <= 1'b0;
         end
      end
   end

   // R5
   head_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept && ftype == FT_HEAD |=> locked && held_port == $past(head_port));
   // R6
   close_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (ftype == FT_TAIL || ftype == FT_SINGLE) |=> !locked);
   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(locked) && $stable(held_port));
endmodule

// File: rtl/hop_src_router.sv
module hop_src_router
   import hop_pkg::*;
#(
   parameter int CODE_W    = 3,
   parameter int MAX_HOPS  = 8,
   parameter int PAYLOAD_W = 32,
   localparam int ROUTE_W  = CODE_W * MAX_HOPS,
   localparam int FLIT_W   = TYPE_W + ROUTE_W + PAYLOAD_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [FLIT_W-1:0]       in_flit,
   output logic [NPORT-1:0]        out_valid,
   input  logic [NPORT-1:0]        out_ready,
   output logic [NPORT*FLIT_W-1:0] out_flit
);
   generate
      if (CODE_W < 3) begin : g_bad_code
         $error("CODE_W must hold five direction codes");
      end
      if (MAX_HOPS < 1) begin : g_bad_hops
         $error("MAX_HOPS must be at least one");
      end
      if (PAYLOAD_W < 1) begin : g_bad_pay
         $error("PAYLOAD_W must be positive");
      end
   endgenerate

   ftype_e               ftype;
   logic [ROUTE_W-1:0]   route_in, route_new;
   logic [PAYLOAD_W-1:0] payload;
   port_e                dec_port, held_port, sel_port;
   logic                 locked, is_hdr, accept;
   logic [FLIT_W-1:0]    fwd_flit;

   assign ftype    = ftype_e'(in_flit[FLIT_W-1 -: TYPE_W]);
   assign route_in = in_flit[PAYLOAD_W +: ROUTE_W];
   assign payload  = in_flit[PAYLOAD_W-1:0];
   assign is_hdr   = (ftype == FT_HEAD) || (ftype == FT_SINGLE);

   hop_dir_decode #(.CODE_W(CODE_W)) u_dec (
      .code (route_in[ROUTE_W-1 -: CODE_W]),
      .port (dec_port)
   );

   hop_route_strip #(.CODE_W(CODE_W), .MAX_HOPS(MAX_HOPS)) u_strip (
      .route_in  (route_in),
      .route_out (route_new)
   );

   hop_port_lock u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .ftype     (ftype),
      .head_port (dec_port),
      .locked    (locked),
      .held_port (held_port)
   );

   always_comb begin
      if (is_hdr)      sel_port = dec_port;
      else if (locked) sel_port = held_port;
      else             sel_port = P_LOCAL;
   end

   assign fwd_flit = is_hdr ? {ftype, route_new, payload} : in_flit;
   assign in_ready = out_ready[sel_port];
   assign accept   = in_valid && in_ready;

   genvar p;
   generate
      for (p = 0; p < NPORT; p++) begin : g_out
         assign out_valid[p] = in_valid && (sel_port == PIDX_W'(p));
         assign out_flit[p*FLIT_W +: FLIT_W] = fwd_flit;
      end
   endgenerate

   // R8
   one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid));
   // R8
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> out_valid == '0);
   // R7
   handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> $onehot(out_valid & out_ready));
   // R7
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_ready |-> (out_valid & out_ready) == '0);
endmodule

// File: tb/hop_src_router_tb.sv
`timescale 1ns/1ps
module hop_src_router_tb;
   localparam int CW = 3, MH = 8, PW = 32;
   localparam int RW = CW * MH;
   localparam int FW = 2 + RW + PW;
   localparam int NP = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [FW-1:0] in_flit = '0;
   logic [NP-1:0] out_valid;
   logic [NP-1:0] out_ready = '0;
   logic [NP*FW-1:0] out_flit;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   // behavioural model state
   bit m_locked = 1'b0;
   int m_held = 4;
   logic [NP-1:0] cap_valid;
   logic [FW-1:0] cap_flit;

   always #2.5 clk = ~clk;

   hop_src_router #(.CODE_W(CW), .MAX_HOPS(MH), .PAYLOAD_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready),
      .out_flit(out_flit));

   function automatic int code_port(input int c);
      case (c)
         1: return 0;
         2: return 1;
         3: return 2;
         4: return 3;
         default: return 4;
      endcase
   endfunction

   function automatic logic [FW-1:0] mk(input int t, input logic [RW-1:0] r,
                                        input logic [PW-1:0] pl);
      return {t[1:0], r, pl};
   endfunction

   task automatic chk(input string req, input logic [FW-1:0] act,
                      input logic [FW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare mid-low phase, advance model at posedge
   task automatic step(input string req, input bit v, input logic [FW-1:0] f,
                       input logic [NP-1:0] rdy);
      int t, port, code;
      logic [FW-1:0] ef;
      logic [NP-1:0] ev;
      logic [RW-1:0] r;
      bit acc;
      @(negedge clk);
      in_valid = v; in_flit = f; out_ready = rdy;
      #1;
      t = int'(f[FW-1 -: 2]);
      r = f[PW +: RW];
      code = int'(r[RW-1 -: CW]);
      if (t == 0 || t == 3) begin
         port = code_port(code);
         ef = {f[FW-1 -: 2], r << CW, f[PW-1:0]};
      end else begin
         port = m_locked ? m_held : 4;
         ef = f;
      end
      ev = v ? (NP'(1) << port) : '0;
      chk({req, " valid"}, FW'(out_valid), FW'(ev));
      chk({req, " ready"}, FW'(in_ready), FW'(rdy[port]));
      if (v) chk({req, " flit"}, out_flit[port*FW +: FW], ef);
      cap_valid = out_valid;
      cap_flit  = out_flit[port*FW +: FW];
      acc = v && rdy[port];
      @(posedge clk);
      if (acc) begin
         if (t == 0) begin m_locked = 1'b1; m_held = port; end
         else if (t == 2 || t == 3) m_locked = 1'b0;
      end
   endtask

   function automatic logic [RW-1:0] rt(input int c0, input int c1, input int c2,
                                        input int c3, input int c4, input int c5);
      return {c0[2:0], c1[2:0], c2[2:0], c3[2:0], c4[2:0], c5[2:0], 6'd0};
   endfunction

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] lf;
      int x, y;
      logic [FW-1:0] f;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state, idle outputs, orphan body goes local
      step("R1", 1'b0, '0, 5'h1F);
      step("R1", 1'b1, mk(1, '1, 32'hDEAD0001), 5'h1F);
      step("R1", 1'b1, mk(2, '0, 32'hDEAD0002), 5'h1F);

      // R2 + R4: each link direction as single flit
      for (int c = 1; c <= 4; c++)
         step("R2_R4", 1'b1, mk(3, rt(c, 2, 3, 4, 1, 5), 32'h1000 + c), 5'h1F);

      // R3: eject and unassigned codes
      step("R3", 1'b1, mk(3, rt(0, 1, 1, 1, 1, 1), 32'h3000), 5'h1F);
      for (int c = 5; c <= 7; c++)
         step("R3", 1'b1, mk(3, rt(c, 0, 0, 0, 0, 0), 32'h3000 + c), 5'h1F);

      // R5: packet to north while other readies toggle
      step("R5", 1'b1, mk(0, rt(3, 1, 0, 0, 0, 0), 32'h5000), 5'b00100);
      step("R5", 1'b1, mk(1, rt(1, 1, 1, 1, 1, 1), 32'h5001), 5'b11111);
      step("R5", 1'b1, mk(1, rt(4, 4, 4, 4, 4, 4), 32'h5002), 5'b00100);
      step("R5", 1'b1, mk(2, rt(2, 0, 0, 0, 0, 0), 32'h5003), 5'b10111);

      // R6: released after tail
      step("R6", 1'b1, mk(1, rt(1, 0, 0, 0, 0, 0), 32'h6000), 5'h1F);

      // R7: head to south stalled, then accepted, body follows
      f = mk(0, rt(4, 2, 0, 0, 0, 0), 32'h7000);
      step("R7", 1'b1, f, 5'b10111);
      step("R7", 1'b1, f, 5'b00111);
      step("R7", 1'b1, mk(1, '0, 32'h7001), 5'b11111);
      step("R7", 1'b1, f, 5'b01000);
      step("R7", 1'b1, mk(1, '0, 32'h7002), 5'b01000);
      step("R7", 1'b0, mk(2, '0, 32'h7003), 5'b01000);
      step("R7", 1'b1, mk(2, '0, 32'h7003), 5'b01000);
      // R6: single flit also closes; next orphan tail goes local
      step("R6", 1'b1, mk(0, rt(2, 0, 0, 0, 0, 0), 32'h6100), 5'h1F);
      step("R6", 1'b1, mk(3, rt(1, 0, 0, 0, 0, 0), 32'h6101), 5'h1F);
      step("R6", 1'b1, mk(2, '0, 32'h6102), 5'h1F);

      // R9: chained hops E,E,N,N,N,eject from (0,0)
      f = mk(3, rt(1, 1, 3, 3, 3, 0), 32'h9000);
      x = 0; y = 0;
      for (int h = 0; h < 6; h++) begin
         step("R9", 1'b1, f, 5'h1F);
         if (cap_valid[0]) x++;
         else if (cap_valid[1]) x--;
         else if (cap_valid[2]) y++;
         else if (cap_valid[3]) y--;
         f = cap_flit;
      end
      chk("R9 x", FW'(x), FW'(2));
      chk("R9 y", FW'(y), FW'(3));
      chk("R9 eject", FW'(cap_valid), FW'(5'b10000));

      // R8 + all: pseudo-random stream against the model
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step("R8", lf[0] | lf[1],
              mk(int'(lf[3:2]), {lf[6:4], lf[9:7], lf[12:10], 15'(lf)}, {lf, ~lf}),
              lf[15:11] | 5'(lf[4]));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule